// File: doc/BRIEF.md
# One-Time-Programmable Area Program Controller

This block is a serial command engine that guards a small one-time-programmable area of 65 bytes: 64 general data bytes and one control byte at index 64. A host drives chip select, serial clock and serial data in, and the block returns serial data out. The host can set a write-enable latch, read a status byte, and send a program command. The program command carries a start address and one or more data bytes. An accepted program command starts a self-timed cycle. The length of that cycle in system clocks is a parameter. When the cycle finishes, the staged bytes are merged into storage, and the merge can only clear bits.

All serial pins are sampled in the system clock domain through a synchronizer, so the serial clock must be well below the system clock. The block has no streaming data path, so all pins are plain control and status signals with no valid/ready handshake and no back-pressure. A combinational debug port reads any stored byte at any time, and an index outside the area reads as 0xFF. Bit 0 of the control byte works as a permanent lock: once it is cleared, the 64 data bytes can never change again.

Top module: `otp_prog_ctrl`

## Requirements
- R1: The serial link uses mode 0 (data sampled on the rising serial-clock edge), most significant bit first. A frame opens when chip select falls and closes when it rises. The command codes are 0x06 for enable-write, 0x05 for status and 0x42 for program.
- R2: In a status frame, the block returns a status byte after the 0x05 code. Bit 0 of this byte is the busy flag and bit 1 is the write-enable latch; the other bits read 0. The byte is fetched again for each further 8 clocks in the same frame.
- R3: An enable-write frame of exactly 8 bits sets the write-enable latch.
- R4: A program frame sent while the write-enable latch is clear changes neither storage nor status.
- R5: A program frame is dropped, with the latch kept and no cycle started, in two cases: chip select rises when the bit count is not a multiple of 8, or the frame holds no data byte after the three address bytes.
- R6: Programming only clears bits. Each targeted byte becomes its old value AND the data byte.
- R7: The low 7 bits of the 24-bit address give the start index, and the index rises by one per data byte. The index does not wrap. Bytes at index 65 or above are discarded, so a start address at or above 65 changes nothing.
- R8: Once bit 0 of byte 64 is 0, later program commands leave bytes 0 to 63 unchanged.
- R9: An accepted program frame sets the busy flag and clears the write-enable latch. Busy stays set for PROG_CYCLES clocks. Storage changes only when busy clears.
- R10: A program frame that starts while busy is ignored. This holds even if busy ends during that frame. The frame does not disturb the running cycle's data, and it leaves the latch as it was.
- R11: After reset, every stored byte is 0xFF and the status byte reads 0x00.
- R12: The debug port returns the stored byte at dbg_addr combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| spi_cs_n | input | 1 | chip select, active low |
| spi_sck | input | 1 | serial clock |
| spi_mosi | input | 1 | serial data into the block |
| spi_miso | output | 1 | serial data out of the block (status) |
| dbg_addr | input | 7 | debug read index |
| dbg_data | output | 8 | stored byte at dbg_addr |

## Verification
The end of the timed cycle (busy falling and the merge into storage) can land in the same clock as a byte being staged for a program frame. The bench provokes this with a long program frame that is opened while busy and still running when the cycle expires. The frame carries 40 data bytes and ends cleanly on a byte boundary with the latch set. It is judged as rejected: the stored bytes after the merge match only the first command, and the status afterwards still shows the latch set. A reference model in the bench tracks storage and compares the debug port on every idle clock.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam logic [7:0] OPC_WREN = 8'h06;
  localparam logic [7:0] OPC_RDSR = 8'h05;
  localparam logic [7:0] OPC_PROG = 8'h42;

  typedef enum logic [2:0] {
    PH_OPC,
    PH_ADDR,
    PH_DATA,
    PH_STAT,
    PH_WEN,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/otp_spi_front.sv
module otp_spi_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       mosi,
  output logic       sel,
  output logic       frame_start,
  output logic       frame_end,
  output logic       bit_stb,
  output logic       byte_stb,
  output logic [7:0] byte_val,
  output logic       on_boundary
);
  logic [SYNC_STAGES-1:0] cs_p, sck_p, mosi_p;
  logic cs_d, sck_d;
  logic [6:0] sh;
  logic [2:0] bcnt;
  logic cs_s, sck_s, mosi_s;

  assign cs_s   = cs_p[SYNC_STAGES-1];
  assign sck_s  = sck_p[SYNC_STAGES-1];
  assign mosi_s = mosi_p[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p   <= '1;
      sck_p  <= '0;
      mosi_p <= '0;
      cs_d   <= 1'b1;
      sck_d  <= 1'b0;
    end else begin
      cs_p   <= {cs_p[SYNC_STAGES-2:0], cs_n};
      sck_p  <= {sck_p[SYNC_STAGES-2:0], sck};
      mosi_p <= {mosi_p[SYNC_STAGES-2:0], mosi};
      cs_d   <= cs_s;
      sck_d  <= sck_s;
    end
  end

  assign sel         = ~cs_s;
  assign frame_start = ~cs_s & cs_d;
  assign frame_end   = cs_s & ~cs_d;
  assign bit_stb     = sel & sck_s & ~sck_d;
  assign byte_stb    = bit_stb & (bcnt == 3'd7);
  assign byte_val    = {sh, mosi_s};
  assign on_boundary = (bcnt == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      bcnt <= '0;
    end else if (frame_start) begin
      sh   <= '0;
      bcnt <= '0;
    end else if (bit_stb) begin
      sh   <= {sh[5:0], mosi_s};
      bcnt <= bcnt + 3'd1;
    end
  end
endmodule

// File: rtl/otp_cmd_decoder.sv
module otp_cmd_decoder
  import otp_pkg::*;
#(
  parameter int DEPTH = 65,
  parameter int IDX_W = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel,
  input  logic                  frame_start,
  input  logic                  frame_end,
  input  logic                  bit_stb,
  input  logic                  byte_stb,
  input  logic [7:0]            byte_val,
  input  logic                  on_boundary,
  input  logic                  wip,
  input  logic                  done,
  output logic                  start,
  output logic                  wel,
  output logic                  miso,
  output logic [DEPTH-1:0][7:0] stage_data,
  output logic [DEPTH-1:0]      stage_vld
);
  localparam logic [IDX_W-1:0] DEPTH_I = IDX_W'(DEPTH);

  phase_t           phase;
  logic [1:0]       acnt;
  logic [IDX_W-1:0] idx;
  logic             got_data;
  logic             rej;
  logic             bad;
  logic [7:0]       stat_sh;
  logic [7:0]       stat_byte;

  assign stat_byte = {6'b0, wel, wip};
  assign start = frame_end && phase == PH_DATA && got_data && on_boundary
                 && wel && !wip && !rej;
  assign miso = sel & stat_sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_OPC;
      acnt     <= '0;
      idx      <= '0;
      got_data <= 1'b0;
      rej      <= 1'b0;
      bad      <= 1'b0;
      stat_sh  <= '0;
      wel      <= 1'b0;
    end else begin
      if (frame_start) begin
        phase    <= PH_OPC;
        acnt     <= '0;
        got_data <= 1'b0;
        rej      <= wip;
        bad      <= 1'b0;
        stat_sh  <= '0;
      end else if (byte_stb) begin
        case (phase)
          PH_OPC: begin
            case (byte_val)
              OPC_PROG: phase <= PH_ADDR;
              OPC_WREN: phase <= PH_WEN;
              OPC_RDSR: begin
                phase   <= PH_STAT;
                stat_sh <= stat_byte;
              end
              default:  phase <= PH_SKIP;
            endcase
          end
          PH_ADDR: begin
            acnt <= acnt + 2'd1;
            if (acnt == 2'd2) begin
              idx   <= byte_val[IDX_W-1:0];
              phase <= PH_DATA;
            end
          end
          PH_DATA: begin
            got_data <= 1'b1;
            if (idx < DEPTH_I) idx <= idx + 1'b1;
          end
          PH_STAT: stat_sh <= stat_byte;
          PH_WEN:  bad <= 1'b1;
          default: ;
        endcase
      end else if (bit_stb && phase == PH_STAT) begin
        stat_sh <= {stat_sh[6:0], 1'b0};
      end

      if (start) wel <= 1'b0;
      else if (frame_end && phase == PH_WEN && !bad && on_boundary) wel <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_data <= '0;
      stage_vld  <= '0;
    end else if (done || (frame_start && !wip)) begin
      stage_vld <= '0;
    end else if (byte_stb && phase == PH_DATA && !rej && !wip && idx < DEPTH_I) begin
      stage_data[idx] <= byte_val;
      stage_vld[idx]  <= 1'b1;
    end
  end
endmodule

// File: rtl/otp_prog_timer.sv
module otp_prog_timer #(
  parameter int PROG_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic wip,
  output logic done
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PROG_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign done = wip && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wip <= 1'b0;
      cnt <= '0;
    end else if (start && !wip) begin
      wip <= 1'b1;
      cnt <= LOAD;
    end else if (done) begin
      wip <= 1'b0;
    end else if (wip) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/otp_store.sv
module otp_store #(
  parameter int DEPTH    = 65,
  parameter int IDX_W    = 7,
  parameter int LOCK_BIT = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  done,
  input  logic [DEPTH-1:0][7:0] stage_data,
  input  logic [DEPTH-1:0]      stage_vld,
  input  logic [IDX_W-1:0]      dbg_addr,
  output logic [7:0]            dbg_data,
  output logic                  locked
);
  localparam logic [IDX_W-1:0] DEPTH_I = IDX_W'(DEPTH);

  logic [DEPTH-1:0][7:0] cells;

  assign locked = ~cells[DEPTH-1][LOCK_BIT];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    localparam bit GUARDED = (g < DEPTH - 1);
    logic [7:0] val;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val <= 8'hFF;
      else if (done && stage_vld[g] && !(GUARDED && locked))
        val <= val & stage_data[g];
    end
    assign cells[g] = val;
  end

  always_comb begin
    dbg_data = 8'hFF;
    if (dbg_addr < DEPTH_I) dbg_data = cells[dbg_addr];
  end
endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl #(
  parameter int DATA_BYTES  = 64,
  parameter int PROG_CYCLES = 2000,
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_BIT    = 0,
  localparam int DEPTH      = DATA_BYTES + 1,
  localparam int IDX_W      = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_cs_n,
  input  logic             spi_sck,
  input  logic             spi_mosi,
  output logic             spi_miso,
  input  logic [IDX_W-1:0] dbg_addr,
  output logic [7:0]       dbg_data
);
  logic sel, frame_start, frame_end, bit_stb, byte_stb, on_boundary;
  logic [7:0] byte_val;
  logic start, wip, wel, done, locked;
  logic [DEPTH-1:0][7:0] stage_data;
  logic [DEPTH-1:0]      stage_vld;

  otp_spi_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi),
    .sel(sel), .frame_start(frame_start), .frame_end(frame_end),
    .bit_stb(bit_stb), .byte_stb(byte_stb), .byte_val(byte_val),
    .on_boundary(on_boundary)
  );

  otp_cmd_decoder #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .sel(sel), .frame_start(frame_start),
    .frame_end(frame_end), .bit_stb(bit_stb), .byte_stb(byte_stb),
    .byte_val(byte_val), .on_boundary(on_boundary), .wip(wip), .done(done),
    .start(start), .wel(wel), .miso(spi_miso),
    .stage_data(stage_data), .stage_vld(stage_vld)
  );

  otp_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .wip(wip), .done(done)
  );

  otp_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .LOCK_BIT(LOCK_BIT)) u_store (
    .clk(clk), .rst_n(rst_n), .done(done), .stage_data(stage_data),
    .stage_vld(stage_vld), .dbg_addr(dbg_addr), .dbg_data(dbg_data),
    .locked(locked)
  );
endmodule

// File: rtl/otp_prog_ctrl_chk.sv
module otp_prog_ctrl_chk #(
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             wip,
  input logic             wel,
  input logic             done,
  input logic             locked,
  input logic [IDX_W-1:0] dbg_addr,
  input logic [7:0]       dbg_data
);
  a_r9_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> wip);
  a_r9_start_drops_wel: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !wel);
  a_r10_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wip |-> !start);
  a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !wip);
  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
  a_r6_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_addr == $past(dbg_addr)) |-> ((dbg_data & ~$past(dbg_data)) == 8'h00));
endmodule

bind otp_prog_ctrl otp_prog_ctrl_chk #(.IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .wip(wip), .wel(wel),
  .done(done), .locked(locked), .dbg_addr(dbg_addr), .dbg_data(dbg_data)
);

// File: tb/otp_prog_ctrl_tb.sv
`timescale 1ns/1ps
module otp_prog_ctrl_tb_top;
  localparam int PROG = 2000;
  localparam int HP   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso;
  logic [6:0] dbg_addr;
  logic [7:0] dbg_data;
  logic [6:0] sweep = '0;
  logic       hold = 1'b0;
  logic [6:0] fix = '0;

  int tests = 0;
  int fails = 0;

  int  mdl [65];
  bit  pending = 0;
  bit  wel_m = 0;
  int  pend_i [$];
  int  pend_d [$];

  always #2.5 clk = ~clk;

  assign dbg_addr = hold ? fix : sweep;

  otp_prog_ctrl #(.PROG_CYCLES(PROG)) dut_i (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso), .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // R12/R6/R11: per-clock comparison against the model while no cycle is pending
  always @(posedge clk) sweep <= (sweep == 7'd69) ? 7'd0 : sweep + 7'd1;
  always @(negedge clk) begin
    if (rst_n && !pending && !hold) begin
      tests++;
      if (int'(dbg_data) != ((sweep < 7'd65) ? mdl[sweep] : 8'hFF)) begin
        fails++;
        $display("FAIL R12 idx=%0d actual=0x%0h expected=0x%0h", sweep, dbg_data,
                 (sweep < 7'd65) ? mdl[sweep] : 8'hFF);
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = tx[i];
      wait_clk(HP);
      rx[i] = miso;
      sck = 1'b1;
      wait_clk(HP);
      sck = 1'b0;
    end
  endtask

  task automatic cs_open();
    cs_n = 1'b0;
    wait_clk(HP);
  endtask

  task automatic cs_close();
    wait_clk(HP);
    cs_n = 1'b1;
    wait_clk(4 * HP);
  endtask

  task automatic rd_status(output logic [7:0] s);
    logic [7:0] dummy;
    cs_open();
    send_bits(8'h05, 8, dummy);
    send_bits(8'h00, 8, s);
    cs_close();
  endtask

  task automatic wren();
    logic [7:0] dummy;
    cs_open();
    send_bits(8'h06, 8, dummy);
    cs_close();
    wel_m = 1;
  endtask

  task automatic prog(input int addr, input int data [$], input int extra);
    logic [7:0] dummy;
    bit busy_start;
    int idx;
    busy_start = pending;
    cs_open();
    send_bits(8'h42, 8, dummy);
    send_bits(8'((addr >> 16) & 255), 8, dummy);
    send_bits(8'((addr >> 8) & 255), 8, dummy);
    send_bits(8'(addr & 255), 8, dummy);
    foreach (data[k]) send_bits(8'(data[k]), 8, dummy);
    if (extra > 0) send_bits(8'h00, extra, dummy);
    cs_close();
    if (!busy_start && wel_m && data.size() > 0 && extra == 0) begin
      wel_m = 0;
      pending = 1;
      idx = addr & 127;
      foreach (data[k]) begin
        if (idx < 65) begin
          pend_i.push_back(idx);
          pend_d.push_back(data[k]);
        end
        idx++;
      end
    end
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    bit lk;
    for (int n = 0; n < 200; n++) begin
      rd_status(s);
      check("R2 latch bit", int'(s[1]), int'(wel_m));
      if (!s[0]) break;
    end
    check("R9 busy clears", int'(s[0]), 0);
    if (pending) begin
      lk = (mdl[64] & 1) == 0;
      foreach (pend_i[k])
        if (!(lk && pend_i[k] < 64)) mdl[pend_i[k]] = mdl[pend_i[k]] & pend_d[k];
      pend_i.delete();
      pend_d.delete();
      pending = 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] s;
    int q [$];
    for (int i = 0; i < 65; i++) mdl[i] = 8'hFF;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // R11 reset status
    rd_status(s);
    check("R11 reset status", int'(s), 8'h00);

    // R4 program without enable
    q = '{8'h00};
    prog(0, q, 0);
    rd_status(s);
    check("R4 no latch, no cycle", int'(s), 8'h00);
    wait_clk(200);

    // R3 enable, R1/R2 status encoding
    wren();
    rd_status(s);
    check("R3 latch set", int'(s), 8'h02);

    // R5 off-boundary end, then data-less frame
    q = '{8'h00};
    prog(1, q, 3);
    rd_status(s);
    check("R5 off-boundary dropped", int'(s), 8'h02);
    q = {};
    prog(1, q, 0);
    rd_status(s);
    check("R5 no data byte dropped", int'(s), 8'h02);
    wait_clk(200);

    // R9/R6 first program
    q = '{8'hF0, 8'h3C};
    prog(3, q, 0);
    hold = 1'b1; fix = 7'd3;
    rd_status(s);
    check("R9 busy and latch cleared", int'(s), 8'h01);
    check("R9 storage unchanged while busy", int'(dbg_data), 8'hFF);
    hold = 1'b0;
    wait_idle();
    hold = 1'b1; fix = 7'd3; wait_clk(1);
    check("R6 byte 3 after program", int'(dbg_data), 8'hF0);
    fix = 7'd4; wait_clk(1);
    check("R7 index advances", int'(dbg_data), 8'h3C);
    hold = 1'b0;

    // R6 AND merge
    wren();
    q = '{8'h0F, 8'hFF};
    prog(3, q, 0);
    wait_idle();
    hold = 1'b1; fix = 7'd3; wait_clk(1);
    check("R6 AND merge", int'(dbg_data), 8'h00);
    fix = 7'd4; wait_clk(1);
    check("R6 ones keep bits", int'(dbg_data), 8'h3C);
    hold = 1'b0;

    // R7 tail with discard, high address bits ignored, out-of-range start
    wren();
    q = '{8'hA1, 8'hB2, 8'hFB, 8'h00, 8'h00};
    prog(62, q, 0);
    wait_idle();
    hold = 1'b1; fix = 7'd64; wait_clk(1);
    check("R7 no wrap, tail discarded", int'(dbg_data), 8'hFB);
    fix = 7'd0; wait_clk(1);
    check("R7 byte 0 untouched by wrap", int'(dbg_data), 8'hFF);
    hold = 1'b0;
    wren();
    q = '{8'h77};
    prog(32'h123405, q, 0);
    wait_idle();
    hold = 1'b1; fix = 7'd5; wait_clk(1);
    check("R7 low 7 address bits", int'(dbg_data), 8'h77);
    hold = 1'b0;
    wren();
    q = '{8'h00};
    prog(70, q, 0);
    wait_idle();

    // R10 busy rejection and a frame straddling the end of the cycle
    wren();
    q = '{8'h55};
    prog(10, q, 0);
    wren();
    q = '{8'h00};
    prog(11, q, 0);
    q = {};
    for (int i = 0; i < 40; i++) q.push_back(8'h00);
    prog(12, q, 0);
    wait_idle();
    rd_status(s);
    check("R10 latch kept after rejects", int'(s), 8'h02);
    hold = 1'b1; fix = 7'd10; wait_clk(1);
    check("R10 running cycle intact", int'(dbg_data), 8'h55);
    fix = 7'd11; wait_clk(1);
    check("R10 busy frame ignored", int'(dbg_data), 8'hFF);
    fix = 7'd30; wait_clk(1);
    check("R10 straddling frame ignored", int'(dbg_data), 8'hFF);
    hold = 1'b0;

    // R8 lock
    q = '{8'hFE};
    prog(64, q, 0);
    wait_idle();
    wren();
    q = '{8'h00};
    prog(20, q, 0);
    wait_idle();
    hold = 1'b1; fix = 7'd20; wait_clk(1);
    check("R8 locked data byte", int'(dbg_data), 8'hFF);
    hold = 1'b0;
    wait_clk(200);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule